// File: doc/BRIEF.md
# UART Programmable Baud Rate Generator

This block turns a base-clock enable pulse into the baud tick that paces a UART transmitter and receiver. A software divisor k (8 to 255) is held in an 8-bit register. A reloading counter produces one pulse for every k base-clock enables. A following half-rate stage turns every second such pulse into one baud tick. The result is one tick for every 2k base enables. The base-clock enable comes from an external prescaler that picks the source clock. The serial shift logic that consumes the tick is outside this block.

The divisor register is written with a one-cycle write strobe and data, and it can always be read back. Two kinds of write are refused, and each refusal sets a sticky error flag that only reset clears. The first is a value below 8. The second is a write of a different value while the transmitter or receiver enable is high. A write that repeats the value already held is always accepted and leaves the running count alone. An accepted divisor change reaches the counter only at the counter's next reload, so no count in progress is ever cut short or stretched. While the power/enable input is low, the counter and the half-rate stage are held cleared and no ticks are produced.

This block has no data stream, so every pin is a plain control or status signal. There is no valid/ready handshake and no back-pressure.

Top module: `baud_rate_gen`

## Requirements
- R1: After reset the divisor readback is 8'hFF (k = 255), the error flag is 0 and the baud tick is 0.
- R2: A write with data below 8 leaves the divisor readback unchanged and sets the error flag to 1 from the next cycle on.
- R3: While tx_enable and rx_enable are both 0, a write of any value from 8 to 255 is accepted, and the readback shows it from the cycle after the write strobe.
- R4: While tx_enable or rx_enable is 1, a write of a value different from the held one leaves the readback unchanged and sets the error flag.
- R5: While tx_enable or rx_enable is 1, a write of the value already held is accepted, does not set the error flag and does not shift the timing of the next baud tick.
- R6: With power on, baud_tick goes high once for every 2k base_en pulses. The first tick after power-up comes in the cycle after the 2k-th base_en pulse. Cycles with base_en low do not advance the count.
- R7: While power_on is 0, no baud tick is produced and the counter and half-rate stage are cleared, so that the count restarts from zero when power returns.
- R8: A divisor accepted in the middle of a count takes effect only after the current count of the old k completes.
- R9: baud_tick is never high for two consecutive cycles.
- R10: The error flag is sticky: once set, it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_en | input | 1 | One-cycle enable from the base-clock prescaler |
| power_on | input | 1 | Generator enable; 0 holds the divider cleared |
| tx_enable | input | 1 | Transmitter enabled; locks the divisor against changes |
| rx_enable | input | 1 | Receiver enabled; locks the divisor against changes |
| wr_en | input | 1 | Divisor register write strobe |
| wr_data | input | 8 | Divisor value to write |
| div_value | output | 8 | Divisor register readback |
| wr_error | output | 1 | Sticky flag for refused writes |
| baud_tick | output | 1 | One-cycle baud-rate enable |

## Verification
A counter that reloads at the wrong value or on the wrong edge shows at the ports as a tick that comes a few base enables early or late. The bench detects this within the first 2k enables by counting ticks exactly at the 2k-1 and 2k boundaries. A half-rate stage that is not cleared while power is off shows as a tick after only k enables following power-up. A write-protection fault shows at once on the readback or on the error flag, in the cycle after the strobe. A divisor that reaches the counter too early moves the boundary of the tick that follows a mid-count rewrite.

// File: rtl/baud_pkg.sv
package baud_pkg;

  localparam int unsigned DIV_W_DEF   = 8;
  localparam int unsigned MIN_DIV_DEF = 8;
  localparam int unsigned RST_DIV_DEF = 255;

  // Outcome of a register write strobe
  typedef enum logic [1:0] {
    WR_NONE   = 2'd0,
    WR_TAKE   = 2'd1,
    WR_TOOLOW = 2'd2,
    WR_LOCKED = 2'd3
  } wr_verdict_e;

endpackage

// File: rtl/baud_div_reg.sv
module baud_div_reg
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W   = DIV_W_DEF,
  parameter int unsigned MIN_DIV = MIN_DIV_DEF,
  parameter int unsigned RST_DIV = RST_DIV_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_data,
  input  logic             tx_enable,
  input  logic             rx_enable,
  output logic [DIV_W-1:0] div_q,
  output logic             err_q
);

  localparam logic [DIV_W-1:0] MIN_K = DIV_W'(MIN_DIV);
  localparam logic [DIV_W-1:0] RST_K = DIV_W'(RST_DIV);

  wr_verdict_e verdict;
  logic        locked;

  assign locked = tx_enable | rx_enable;

  always_comb begin
    verdict = WR_NONE;
    if (wr_en) begin
      if (wr_data < MIN_K)                 verdict = WR_TOOLOW;
      else if (locked && wr_data != div_q) verdict = WR_LOCKED;
      else                                 verdict = WR_TAKE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= RST_K;
      err_q <= 1'b0;
    end else begin
      case (verdict)
        WR_TAKE:              div_q <= wr_data;
        WR_TOOLOW, WR_LOCKED: err_q <= 1'b1;
        default: ;
      endcase
    end
  end

  // Low values never land in the register
  assert_low_rejected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data < MIN_K) |=> ($stable(div_q) && err_q));

  // Changes while locked are refused
  assert_locked_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && locked && wr_data != div_q) |=> ($stable(div_q) && err_q));

  // Free writes in range are taken
  assert_free_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !locked && wr_data >= MIN_K) |=> (div_q == $past(wr_data)));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

endmodule

// File: rtl/baud_div_count.sv
module baud_div_count #(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned RST_DIV = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             power_on,
  input  logic             base_en,
  input  logic [DIV_W-1:0] next_k,
  output logic             cnt_pulse
);

  localparam logic [DIV_W-1:0] RST_K = DIV_W'(RST_DIV);
  localparam logic [DIV_W-1:0] ONE   = DIV_W'(1);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] active_k;
  logic             at_end;

  assign at_end    = (cnt == active_k - ONE);
  assign cnt_pulse = power_on & base_en & at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      active_k <= RST_K;
    end else if (!power_on) begin
      cnt      <= '0;
      active_k <= next_k;
    end else if (base_en) begin
      if (at_end) begin
        cnt      <= '0;
        active_k <= next_k;   // divisor switches only at reload
      end else begin
        cnt <= cnt + ONE;
      end
    end
  end

  assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < active_k);

  assert_off_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !power_on |=> (cnt == '0));

  // Divisor is frozen between reloads
  assert_k_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (power_on && !cnt_pulse) |=> $stable(active_k));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (power_on && !base_en) |=> $stable(cnt));

endmodule

// File: rtl/baud_half_rate.sv
module baud_half_rate (
  input  logic clk,
  input  logic rst_n,
  input  logic power_on,
  input  logic cnt_pulse,
  output logic tick_q
);

  logic half;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half   <= 1'b0;
      tick_q <= 1'b0;
    end else if (!power_on) begin
      half   <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= cnt_pulse & half;
      if (cnt_pulse) half <= ~half;
    end
  end

  assert_tick_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);

  assert_no_tick_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !power_on |=> !tick_q);

endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W   = DIV_W_DEF,
  parameter int unsigned MIN_DIV = MIN_DIV_DEF,
  parameter int unsigned RST_DIV = RST_DIV_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_en,
  input  logic             power_on,
  input  logic             tx_enable,
  input  logic             rx_enable,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_data,
  output logic [DIV_W-1:0] div_value,
  output logic             wr_error,
  output logic             baud_tick
);

  logic cnt_pulse;

  baud_div_reg #(
    .DIV_W  (DIV_W),
    .MIN_DIV(MIN_DIV),
    .RST_DIV(RST_DIV)
  ) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .tx_enable(tx_enable),
    .rx_enable(rx_enable),
    .div_q    (div_value),
    .err_q    (wr_error)
  );

  baud_div_count #(
    .DIV_W  (DIV_W),
    .RST_DIV(RST_DIV)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .power_on (power_on),
    .base_en  (base_en),
    .next_k   (div_value),
    .cnt_pulse(cnt_pulse)
  );

  baud_half_rate u_half (
    .clk      (clk),
    .rst_n    (rst_n),
    .power_on (power_on),
    .cnt_pulse(cnt_pulse),
    .tick_q   (baud_tick)
  );

  assert_reset_value_R1: assert property (@(posedge clk)
    !rst_n |=> (div_value == DIV_W'(RST_DIV) && !wr_error && !baud_tick));

endmodule

// File: tb/sim_baud_rate_gen.sv
`timescale 1ns/1ps
module sim_baud_rate_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_en = 1'b0;
  logic       power_on = 1'b0;
  logic       tx_enable = 1'b0;
  logic       rx_enable = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] div_value;
  logic       wr_error;
  logic       baud_tick;

  int errors = 0;
  int checks = 0;
  int ticks  = 0;

  always #2 clk = ~clk;

  baud_rate_gen u0 (
    .clk(clk), .rst_n(rst_n), .base_en(base_en), .power_on(power_on),
    .tx_enable(tx_enable), .rx_enable(rx_enable), .wr_en(wr_en),
    .wr_data(wr_data), .div_value(div_value), .wr_error(wr_error),
    .baud_tick(baud_tick)
  );

  always @(negedge clk) if (baud_tick) ticks++;

  // {k, enable count, expected ticks}
  localparam logic [31:0] VEC [8] = '{
    {8'd8,   16'd15,  8'd0},
    {8'd8,   16'd16,  8'd1},
    {8'd10,  16'd40,  8'd2},
    {8'd9,   16'd53,  8'd2},
    {8'd100, 16'd600, 8'd3},
    {8'd255, 16'd509, 8'd0},
    {8'd255, 16'd510, 8'd1},
    {8'd13,  16'd78,  8'd3}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); base_en = 1'b1;
    end
    @(negedge clk); base_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic restart(input logic [7:0] k);
    power_on = 1'b0; tx_enable = 1'b0; rx_enable = 1'b0;
    wr(k);
    repeat (2) @(negedge clk);
    ticks = 0;
    power_on = 1'b1;
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0; power_on = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 readback", div_value, 8'hFF);
    chk("R1 error", wr_error, 0);
    chk("R1 tick", baud_tick, 0);

    // R6 table of divide ratios
    foreach (VEC[i]) begin
      restart(VEC[i][31:24]);
      pulses(int'(VEC[i][23:8]));
      chk("R6 ticks per 2k", ticks, int'(VEC[i][7:0]));
    end

    // R3 free write readback
    do_reset();
    wr(8'd77);
    chk("R3 readback", div_value, 77);
    chk("R3 no error", wr_error, 0);

    // R5 same-value write while enabled, count undisturbed
    restart(8'd8);
    tx_enable = 1'b1;
    pulses(5);
    wr(8'd8);
    chk("R5 readback", div_value, 8);
    chk("R5 no error", wr_error, 0);
    pulses(10);
    chk("R5 no early tick", ticks, 0);
    pulses(1);
    chk("R5 tick at 2k", ticks, 1);

    // R4 different value while rx enabled
    tx_enable = 1'b0; rx_enable = 1'b1;
    wr(8'd20);
    chk("R4 readback held", div_value, 8);
    chk("R4 error set", wr_error, 1);

    // R10 sticky error after unlock and good write
    rx_enable = 1'b0;
    wr(8'd30);
    chk("R10 error stays", wr_error, 1);

    // R2 low value refused
    do_reset();
    wr(8'd7);
    chk("R2 readback held", div_value, 8'hFF);
    chk("R2 error set", wr_error, 1);
    wr(8'd0);
    chk("R2 zero refused", div_value, 8'hFF);

    // R8 mid-count divisor change
    restart(8'd8);
    pulses(4);
    wr(8'd16);
    chk("R8 readback", div_value, 16);
    pulses(19);
    chk("R8 old k finishes, new k pending", ticks, 0);
    pulses(1);
    chk("R8 tick at 8+16", ticks, 1);

    // R7 power off: no ticks, half stage cleared
    restart(8'd8);
    pulses(8);            // half stage now set
    power_on = 1'b0;
    ticks = 0;
    pulses(40);
    chk("R7 no tick while off", ticks, 0);
    power_on = 1'b1;
    pulses(15);
    chk("R7 restart from zero", ticks, 0);
    pulses(1);
    chk("R7 first tick at 2k", ticks, 1);

    // R9 tick width with base_en held every cycle
    restart(8'd8);
    ticks = 0;
    pulses(64);
    chk("R9 single-cycle ticks", ticks, 4);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule